// File: doc/BRIEF.md
# Sample Phase Calibration Engine

This block calibrates the receive sample phase of a card interface. On a start pulse it captures the phase that is currently programmed. It then steps through every one of the eight sample phases, and at each phase it asks an external agent to perform one tuning read. The agent answers with a single result pulse. The result carries a command-error flag, a data-error flag and a pattern-match flag. The engine collects one pass bit per phase into an eight-bit map.

When the sweep is complete, the engine searches the map for a phase that sits in the middle of a run of passing phases. It treats the map as circular. A run of five passing phases (the centre plus two on each side) is preferred. If no such run exists, a run of three passing phases is accepted. The chosen phase is written back through the phase-set port. If neither kind of run exists, the engine reports failure and writes no phase.

Issuing the card commands and comparing the returned data are outside the block. Both are modelled by the request/result handshake.

Top module: `rx_phase_calib`

## Requirements
- R1: After reset, done_o, fail_o, test_req_o, tmo_load_o and phase_we_o are 0 and best_o is 0.
- R2: A sweep captures cur_phase_i on the start cycle. The first test uses that phase plus one (mod 8), and each later test uses the previous test's phase plus one (mod 8). Changes on cur_phase_i after the start cycle have no effect.
- R3: Each sweep issues exactly 8 test requests. The last request is at the captured starting phase, and done_o follows it.
- R4: The bit for a phase in the pass map is set only if that phase's result has res_cmd_err_i = 0, res_dat_err_i = 0 and res_match_i = 1. Any error flag marks the phase failing, even when res_match_i = 1.
- R5: The chosen phase is the lowest index p such that phases p-2, p-1, p, p+1 and p+2 (mod 8) all passed. Such a phase is preferred over any phase that only qualifies under R6.
- R6: If no phase qualifies under R5, the chosen phase is the lowest p such that phases p-1, p and p+1 (mod 8) all passed.
- R7: If no phase qualifies under R5 or R6, fail_o is 1 in the done cycle and phase_we_o stays 0 in that cycle.
- R8: Every test request is accompanied in the same cycle by tmo_load_o (set the data timeout to its maximum) and by phase_we_o with phase_o equal to the phase under test.
- R9: No new test request is raised while an earlier one is still waiting for its res_valid_i pulse.
- R10: done_o is high for exactly one cycle per sweep. fail_o and best_o change only in a cycle where done_o is high, and otherwise hold their values.
- R11: A start pulse that arrives while a sweep is in progress is ignored.
- R12: On success, in the done cycle phase_we_o is 1, phase_o equals the chosen phase, best_o equals the chosen phase, and fail_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that begins a sweep |
| cur_phase_i | input | 3 | Currently programmed sample phase |
| res_valid_i | input | 1 | One-cycle pulse: the result of the outstanding test is valid |
| res_cmd_err_i | input | 1 | Test result: command error |
| res_dat_err_i | input | 1 | Test result: data error |
| res_match_i | input | 1 | Test result: returned block matched the expected pattern |
| test_req_o | output | 1 | One-cycle strobe requesting a tuning read |
| tmo_load_o | output | 1 | Strobe: load the maximum data timeout |
| phase_we_o | output | 1 | Strobe: program phase_o as the sample phase |
| phase_o | output | 3 | Phase value to program |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |
| fail_o | output | 1 | Last sweep found no usable phase |
| best_o | output | 3 | Phase chosen by the last successful sweep |

## Verification
The assertions assume the following about the agent: it gives exactly one res_valid_i pulse per request, that pulse comes at least one cycle after the request, and start_i is a single-cycle pulse. The bench agent waits a varying delay of one to four cycles after each request and then answers once. For each failing phase it rotates between a command error, a data error and a plain mismatch. The bench also fires a second start pulse in the middle of one sweep, and it changes cur_phase_i after every start. Both are done to confirm that neither disturbs the sweep in progress.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_WAIT,
    ST_PICK,
    ST_FIN
  } cal_state_e;
endpackage

// File: rtl/calib_passmap.sv
module calib_passmap #(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           upd_i,
  input  logic [PW-1:0]  idx_i,
  input  logic           pass_i,
  output logic [NPH-1:0] map_o
);
  // one flop per phase, each with its own clock enable
  for (genvar g = 0; g < NPH; g++) begin : g_bit
    logic hit_en;
    assign hit_en = upd_i && (idx_i == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       map_o[g] <= 1'b0;
      else if (clr_i)   map_o[g] <= 1'b0;
      else if (hit_en)  map_o[g] <= pass_i;
    end
  end
endmodule

// File: rtl/calib_pick.sv
module calib_pick #(
  parameter int NPH      = 8,
  parameter int WIDE_R   = 2,
  parameter int NARROW_R = 1,
  localparam int PW = $clog2(NPH)
) (
  input  logic [NPH-1:0] map_i,
  output logic           found_o,
  output logic [PW-1:0]  idx_o
);
  logic [NPH-1:0] wide_ok;
  logic [NPH-1:0] narrow_ok;

  // circular window test per candidate centre
  for (genvar i = 0; i < NPH; i++) begin : g_ctr
    logic [2*WIDE_R:0]   wbits;
    logic [2*NARROW_R:0] nbits;
    for (genvar j = 0; j <= 2*WIDE_R; j++) begin : g_w
      assign wbits[j] = map_i[(i + j - WIDE_R + NPH) % NPH];
    end
    for (genvar j = 0; j <= 2*NARROW_R; j++) begin : g_n
      assign nbits[j] = map_i[(i + j - NARROW_R + NPH) % NPH];
    end
    assign wide_ok[i]   = &wbits;
    assign narrow_ok[i] = &nbits;
  end

  // lowest index wins; any wide window beats every narrow one
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (narrow_ok[i]) begin
        found_o = 1'b1;
        idx_o   = PW'(i);
      end
    end
    if (|wide_ok) begin
      for (int i = NPH - 1; i >= 0; i--) begin
        if (wide_ok[i]) idx_o = PW'(i);
      end
    end
  end
endmodule

// File: rtl/calib_seq.sv
module calib_seq
  import calib_pkg::*;
#(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] cur_phase_i,
  input  logic          res_valid_i,
  input  logic          found_i,
  input  logic [PW-1:0] pick_i,
  output logic          test_req_o,
  output logic          tmo_load_o,
  output logic          phase_we_o,
  output logic [PW-1:0] phase_o,
  output logic          map_clr_o,
  output logic          map_upd_o,
  output logic [PW-1:0] map_idx_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [PW-1:0] best_o
);
  cal_state_e    st_q, st_d;
  logic [PW-1:0] ph_q, ph_d, nxt_ph;
  logic [PW-1:0] org_q;
  logic          ph_en, org_en, res_en;
  logic          fail_q;
  logic [PW-1:0] best_q;

  assign nxt_ph    = ph_q + PW'(1);
  assign map_idx_o = ph_q;
  assign fail_o    = fail_q;
  assign best_o    = best_q;

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    ph_en      = 1'b0;
    org_en     = 1'b0;
    res_en     = 1'b0;
    test_req_o = 1'b0;
    tmo_load_o = 1'b0;
    phase_we_o = 1'b0;
    phase_o    = ph_q;
    map_clr_o  = 1'b0;
    map_upd_o  = 1'b0;
    done_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          org_en    = 1'b1;
          ph_en     = 1'b1;
          ph_d      = cur_phase_i;
          map_clr_o = 1'b1;
          st_d      = ST_STEP;
        end
      end
      ST_STEP: begin
        phase_o    = nxt_ph;
        phase_we_o = 1'b1;
        tmo_load_o = 1'b1;
        test_req_o = 1'b1;
        ph_en      = 1'b1;
        ph_d       = nxt_ph;
        st_d       = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid_i) begin
          map_upd_o = 1'b1;
          st_d      = (ph_q == org_q) ? ST_PICK : ST_STEP;
        end
      end
      ST_PICK: begin
        res_en = 1'b1;
        st_d   = ST_FIN;
      end
      ST_FIN: begin
        done_o     = 1'b1;
        phase_we_o = !fail_q;
        phase_o    = best_q;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      org_q <= '0;
    end else begin
      if (ph_en)  ph_q  <= ph_d;
      if (org_en) org_q <= cur_phase_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      best_q <= '0;
    end else if (res_en) begin
      fail_q <= !found_i;
      if (found_i) best_q <= pick_i;
    end
  end
endmodule

// File: rtl/rx_phase_calib.sv
module rx_phase_calib #(
  parameter int NPH      = 8,
  parameter int WIDE_R   = 2,
  parameter int NARROW_R = 1,
  localparam int PW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] cur_phase_i,
  input  logic          res_valid_i,
  input  logic          res_cmd_err_i,
  input  logic          res_dat_err_i,
  input  logic          res_match_i,
  output logic          test_req_o,
  output logic          tmo_load_o,
  output logic          phase_we_o,
  output logic [PW-1:0] phase_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [PW-1:0] best_o
);
  logic [1:0]     rsync_q;
  logic           rst_core_n;
  logic           res_ok;
  logic           map_clr, map_upd;
  logic [PW-1:0]  map_idx;
  logic [NPH-1:0] pass_map;
  logic           found;
  logic [PW-1:0]  pick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign res_ok = !res_cmd_err_i && !res_dat_err_i && res_match_i;

  calib_seq #(.NPH(NPH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (start_i),
    .cur_phase_i (cur_phase_i),
    .res_valid_i (res_valid_i),
    .found_i     (found),
    .pick_i      (pick),
    .test_req_o  (test_req_o),
    .tmo_load_o  (tmo_load_o),
    .phase_we_o  (phase_we_o),
    .phase_o     (phase_o),
    .map_clr_o   (map_clr),
    .map_upd_o   (map_upd),
    .map_idx_o   (map_idx),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .best_o      (best_o)
  );

  calib_passmap #(.NPH(NPH)) u_map (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (map_clr),
    .upd_i  (map_upd),
    .idx_i  (map_idx),
    .pass_i (res_ok),
    .map_o  (pass_map)
  );

  calib_pick #(.NPH(NPH), .WIDE_R(WIDE_R), .NARROW_R(NARROW_R)) u_pick (
    .map_i   (pass_map),
    .found_o (found),
    .idx_o   (pick)
  );
endmodule

// File: rtl/calib_chk.sv
module calib_chk #(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_req_o,
  input logic          tmo_load_o,
  input logic          phase_we_o,
  input logic [PW-1:0] phase_o,
  input logic          res_valid_i,
  input logic          done_o,
  input logic          fail_o,
  input logic [PW-1:0] best_o
);
  logic          outst_q;
  logic [PW:0]   cnt_q;
  logic [PW-1:0] last_ph_q;
  logic [PW-1:0] exp_nxt;

  assign exp_nxt = last_ph_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q   <= 1'b0;
      cnt_q     <= '0;
      last_ph_q <= '0;
    end else begin
      if (test_req_o)       outst_q <= 1'b1;
      else if (res_valid_i) outst_q <= 1'b0;
      if (done_o)           cnt_q <= '0;
      else if (test_req_o)  cnt_q <= cnt_q + (PW+1)'(1);
      if (test_req_o)       last_ph_q <= phase_o;
    end
  end

  p_tmo_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> (tmo_load_o && phase_we_o));

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> !outst_q);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && cnt_q != '0) |-> (phase_o == exp_nxt));

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == (PW+1)'(NPH)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fail_o) || !$stable(best_o)) |-> done_o);

  p_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_o) |-> (phase_we_o && phase_o == best_o));

  p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> !phase_we_o);
endmodule

bind rx_phase_calib calib_chk #(.NPH(NPH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .test_req_o  (test_req_o),
  .tmo_load_o  (tmo_load_o),
  .phase_we_o  (phase_we_o),
  .phase_o     (phase_o),
  .res_valid_i (res_valid_i),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .best_o      (best_o)
);

// File: tb/rx_phase_calib_test.sv
module rx_phase_calib_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, start_i;
  logic [2:0] cur_phase_i;
  logic       res_valid_i, res_cmd_err_i, res_dat_err_i, res_match_i;
  logic       test_req_o, tmo_load_o, phase_we_o, done_o, fail_o;
  logic [2:0] phase_o, best_o;

  rx_phase_calib uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_phase_i(cur_phase_i),
    .res_valid_i(res_valid_i), .res_cmd_err_i(res_cmd_err_i),
    .res_dat_err_i(res_dat_err_i), .res_match_i(res_match_i),
    .test_req_o(test_req_o), .tmo_load_o(tmo_load_o), .phase_we_o(phase_we_o),
    .phase_o(phase_o), .done_o(done_o), .fail_o(fail_o), .best_o(best_o)
  );

  typedef struct {
    bit       fail;
    bit [2:0] best;
    string    tag;
  } exp_t;

  exp_t     exp_q[$];
  int       checks = 0;
  int       errors = 0;
  bit [7:0] pat_g;
  bit [2:0] exp_ph;
  bit [2:0] sp_g;
  int       req_n;
  int       sweep_n = 0;
  bit       done_seen;
  bit       hold_bad;
  bit       fail_prev;
  bit [2:0] best_prev;
  bit       mon_on = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic void ref_pick(input bit [7:0] m, output bit ok, output bit [2:0] b);
    bit [15:0] dbl;
    bit [7:0]  r;
    ok = 0;
    b  = 0;
    dbl = {m, m};
    for (int i = 0; i < 8 && !ok; i++) begin
      r = 8'(dbl >> i);
      if ((r & 8'hC7) == 8'hC7) begin ok = 1; b = 3'(i); end
    end
    for (int i = 0; i < 8 && !ok; i++) begin
      r = 8'(dbl >> i);
      if ((r & 8'h83) == 8'h83) begin ok = 1; b = 3'(i); end
    end
  endfunction

  // test agent: answers each request once after a varying delay
  initial begin
    res_valid_i = 0; res_cmd_err_i = 0; res_dat_err_i = 0; res_match_i = 0;
    @(negedge clk);
    forever begin
      if (test_req_o) begin
        bit [2:0] ph;
        int       lat;
        bit       dup;
        ph = phase_o;
        chk(ph == exp_ph, "R2", "tested phase", ph, exp_ph);
        chk(tmo_load_o && phase_we_o, "R8", "timeout/phase strobes", {tmo_load_o, phase_we_o}, 3);
        exp_ph = ph + 3'd1;
        req_n++;
        lat = (int'(ph) + sweep_n) % 4;
        dup = 0;
        repeat (lat + 1) begin
          @(negedge clk);
          if (test_req_o) dup = 1;
        end
        chk(!dup, "R9", "request while outstanding", dup, 0);
        res_valid_i = 1;
        if (pat_g[ph]) begin
          res_cmd_err_i = 0; res_dat_err_i = 0; res_match_i = 1;
        end else begin
          case (ph % 3)
            0: begin res_cmd_err_i = 1; res_dat_err_i = 0; res_match_i = 1; end
            1: begin res_cmd_err_i = 0; res_dat_err_i = 1; res_match_i = 1; end
            default: begin res_cmd_err_i = 0; res_dat_err_i = 0; res_match_i = 0; end
          endcase
        end
        @(negedge clk);
        res_valid_i = 0; res_cmd_err_i = 0; res_dat_err_i = 0; res_match_i = 0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // monitor: compares results against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (done_o) begin
          exp_t e;
          if (exp_q.size() == 0) begin
            chk(0, "R10", "unexpected done", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(!hold_bad, "R10", "results held between sweeps", hold_bad, 0);
            chk(req_n == 8, "R3", "requests per sweep", req_n, 8);
            chk(exp_ph - 3'd1 == sp_g, "R3", "last tested phase", exp_ph - 3'd1, sp_g);
            if (e.fail) begin
              chk(fail_o == 1, "R7", "fail flag", fail_o, 1);
              chk(phase_we_o == 0, "R7", "no phase write on failure", phase_we_o, 0);
            end else begin
              chk(fail_o == 0, e.tag, "fail flag", fail_o, 0);
              chk(best_o == e.best, e.tag, "chosen phase", best_o, e.best);
              chk(phase_we_o && phase_o == e.best, "R12", "phase write of choice",
                  phase_we_o ? int'(phase_o) : -1, e.best);
            end
          end
          fail_prev = fail_o;
          best_prev = best_o;
          hold_bad  = 0;
          done_seen = 1;
          @(negedge clk);
          chk(!done_o, "R10", "done width", done_o, 0);
        end else if (fail_o !== fail_prev || best_o !== best_prev) begin
          hold_bad = 1;
        end
      end
    end
  end

  task automatic sweep(input bit [2:0] sp, input bit [7:0] pat, input string tag,
                       input bit restart);
    exp_t e;
    bit   ok;
    bit [2:0] b;
    int   w;
    ref_pick(pat, ok, b);
    e.fail = !ok; e.best = b; e.tag = tag;
    exp_q.push_back(e);
    pat_g = pat; sp_g = sp; exp_ph = sp + 3'd1; req_n = 0; done_seen = 0;
    sweep_n++;
    @(negedge clk);
    cur_phase_i = sp;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    cur_phase_i = sp + 3'd3;
    if (restart) begin
      repeat (6) @(negedge clk);
      cur_phase_i = sp + 3'd5;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    w = 0;
    while (!done_seen && w < 2000) begin
      @(negedge clk);
      w++;
    end
    if (!done_seen) chk(0, "R3", "sweep never completed", 0, 1);
    if (restart) chk(req_n == 8, "R11", "requests with extra start", req_n, 8);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; cur_phase_i = 0;
    fail_prev = 0; best_prev = 0; hold_bad = 0;
    repeat (3) @(negedge clk);
    chk(done_o == 0 && fail_o == 0, "R1", "done/fail in reset", {done_o, fail_o}, 0);
    chk(test_req_o == 0 && tmo_load_o == 0 && phase_we_o == 0, "R1", "strobes in reset",
        {test_req_o, tmo_load_o, phase_we_o}, 0);
    chk(best_o == 0, "R1", "best in reset", best_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(done_o == 0 && test_req_o == 0 && fail_o == 0, "R1", "idle after release",
        {done_o, test_req_o, fail_o}, 0);
    mon_on = 1;

    sweep(3'd3, 8'hFF, "R5", 0);   // all pass, lowest centre 0
    sweep(3'd5, 8'h3E, "R5", 0);   // centre 3
    sweep(3'd0, 8'hE3, "R5", 0);   // window wraps, centre 7
    sweep(3'd2, 8'hF3, "R5", 0);   // wide at 6 beats narrow at 0
    sweep(3'd6, 8'h0E, "R6", 0);   // narrow only, centre 2
    sweep(3'd1, 8'hC1, "R6", 0);   // narrow wraps, centre 7
    sweep(3'd2, 8'h55, "R7", 0);   // no window
    sweep(3'd7, 8'h00, "R7", 0);   // nothing passes
    sweep(3'd4, 8'h7C, "R4", 0);   // errors with match set must fail
    sweep(3'd2, 8'h1C, "R11", 1);  // extra start mid-sweep

    chk(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule